// File: doc/BRIEF.md
# Asynchronous serial byte transmitter with completion handshake

The block sends one byte as an asynchronous serial frame on a single output line. A frame is a low start bit, the eight data bits with the least significant bit first, an odd parity bit and a high stop bit. Each of these bits stays on the line for one bit period, which is the clock frequency divided by the baud rate, counted in whole clock cycles. When no frame is being sent, the line rests high.

A client puts a byte on `din` and raises `send_req`. The block captures the byte on the first clock edge on which it sees the request. It then sends the frame and raises `sent`. `sent` stays high until the client lowers `send_req`, which closes a four-phase request/acknowledge exchange. A request that stays high after the frame cannot start a second frame, because the block waits for the request to fall. Inside, a bit-period timer, a data-bit counter and a loadable right-shifting frame register are driven by strobes from a small control state machine.

Top module: `serial_tx_hs`

## Requirements
- R1: `rst` is active high and asynchronous. While it is high, `sout` is 1 and `sent` is 0, and this holds even when reset arrives in the middle of a frame.
- R2: While no request has been accepted, `sout` stays 1 and `sent` stays 0.
- R3: The frame starts on the first rising edge at which `send_req` is 1 in the idle state (edge k). `sout` is then 0 for the start bit. Each bit lasts DIV = CLK_HZ / BAUD clock cycles, so bit j of the frame occupies edges k + j*DIV up to k + (j+1)*DIV - 1.
- R4: Frame bits 1 to 8 carry `din[0]` up to `din[7]` in that order, so the least significant bit goes first.
- R5: Frame bit 9 is the parity bit. It is 1 when the data byte has an even number of ones, so the nine bits together hold an odd number of ones.
- R6: Frame bit 10 is the stop bit and is 1. `sent` stays 0 during the frame and becomes 1 at edge k + 11*DIV.
- R7: While `send_req` stays 1 after the frame, `sent` stays 1 and `sout` stays 1. No second frame starts.
- R8: `sent` returns to 0 on the first rising edge at which `send_req` is sampled 0. From the next edge on, a new request is accepted.
- R9: `din` is sampled only at edge k. Changes to `din` during the frame do not change the bits that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| send_req | input | 1 | Request to send the byte on `din` |
| din | input | DATA_W (8) | Byte to be sent |
| sent | output | 1 | Acknowledge: the frame is finished. Held until `send_req` falls |
| sout | output | 1 | Serial line, high when idle |

## Verification
Every output result is due a fixed number of edges after the request edge k. The start bit appears one register after k. Bit j holds from k + j*DIV, `sent` rises at k + 11*DIV, and `sent` falls one edge after `send_req` is seen low. The bench counts those edges from k and samples each bit half a bit period into its window, one time unit after a rising edge. It also checks `sent` one cycle before and at edge k + 11*DIV. A one-cycle error in the bit period therefore adds up across the eleven bits and moves a sample out of its window. `din` is altered right after k, reset is applied asynchronously in the middle of a frame, and the request is held long past the end of a frame, so that R9, R1 and R7 can be seen at the ports.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_ACK
    } tx_state_e;
endpackage

// File: rtl/baud_timer.sv
module baud_timer #(
    parameter int DIV = 5208
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic done_o
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tim_s;

    tim_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == LAST) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign done_o = (r_q.cnt == LAST);

    // R3
    timer_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (r_q.cnt == '0));
endmodule

// File: rtl/bit_counter.sv
module bit_counter #(
    parameter int NBITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic done_o
);
    localparam int W = (NBITS > 2) ? $clog2(NBITS) : 1;
    localparam logic [W-1:0] LAST = W'(NBITS - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } bc_s;

    bc_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.cnt = '0;
        end else if (inc_i) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign done_o = (r_q.cnt == LAST);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        inc_i |-> !done_o);
endmodule

// File: rtl/frame_shreg.sv
module frame_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              bit0_o,
    output logic              par_o
);
    localparam int FW = DATA_W + 2;

    typedef struct packed {
        logic [FW-1:0] frame;
        logic          par;
    } fr_s;

    fr_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.frame = {1'b1, din_i, 1'b0};
            r_d.par   = ~(^din_i);
        end else if (shift_i) begin
            r_d.frame = {1'b1, r_q.frame[FW-1:1]};
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r_q <= '1;
        else     r_q <= r_d;
    end

    assign bit0_o = r_q.frame[0];
    assign par_o  = r_q.par;

    // R9
    load_frame_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (!r_q.frame[0] && r_q.frame[FW-1]));

    // R4
    fill_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !load_i) |=> r_q.frame[FW-1]);
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
    import serial_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic send_req_i,
    input  logic timer_done_i,
    input  logic bit_done_i,
    output logic load_o,
    output logic shift_o,
    output logic clr_timer_o,
    output logic clr_bit_o,
    output logic inc_bit_o,
    output logic sel_par_o,
    output logic busy_o,
    output logic sent_o
);
    typedef struct packed {
        tx_state_e st;
    } ctl_s;

    ctl_s r_d, r_q;

    always_comb begin
        r_d         = r_q;
        load_o      = 1'b0;
        shift_o     = 1'b0;
        clr_timer_o = 1'b0;
        clr_bit_o   = 1'b0;
        inc_bit_o   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                clr_timer_o = 1'b1;
                clr_bit_o   = 1'b1;
                if (send_req_i) begin
                    load_o   = 1'b1;
                    r_d.st   = ST_START;
                end
            end
            ST_START: begin
                if (timer_done_i) begin
                    shift_o = 1'b1;
                    r_d.st  = ST_DATA;
                end
            end
            ST_DATA: begin
                if (timer_done_i) begin
                    shift_o = 1'b1;
                    if (bit_done_i) r_d.st = ST_PARITY;
                    else            inc_bit_o = 1'b1;
                end
            end
            ST_PARITY: begin
                if (timer_done_i) r_d.st = ST_STOP;
            end
            ST_STOP: begin
                if (timer_done_i) r_d.st = ST_ACK;
            end
            ST_ACK: begin
                clr_timer_o = 1'b1;
                if (!send_req_i) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) r_q.st <= ST_IDLE;
        else     r_q    <= r_d;
    end

    assign sent_o    = (r_q.st == ST_ACK);
    assign sel_par_o = (r_q.st == ST_PARITY);
    assign busy_o    = (r_q.st == ST_START) || (r_q.st == ST_DATA) ||
                       (r_q.st == ST_PARITY) || (r_q.st == ST_STOP);

    // R7
    sent_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sent_o && send_req_i) |=> sent_o);

    // R8
    sent_release_chk: assert property (@(posedge clk) disable iff (rst)
        (sent_o && !send_req_i) |=> !sent_o);
endmodule

// File: rtl/serial_tx_hs.sv
module serial_tx_hs #(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 19_200,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send_req,
    input  logic [DATA_W-1:0] din,
    output logic              sent,
    output logic              sout
);
    localparam int DIV = CLK_HZ / BAUD;

    logic load, shift, clr_timer, clr_bit, inc_bit, sel_par, busy;
    logic timer_done, bit_done, frame_bit, par_bit;

    baud_timer #(.DIV(DIV)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_timer),
        .done_o (timer_done)
    );

    bit_counter #(.NBITS(DATA_W)) bits_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_bit),
        .inc_i  (inc_bit),
        .done_o (bit_done)
    );

    frame_shreg #(.DATA_W(DATA_W)) shreg_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .shift_i (shift),
        .din_i   (din),
        .bit0_o  (frame_bit),
        .par_o   (par_bit)
    );

    tx_ctrl ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .send_req_i   (send_req),
        .timer_done_i (timer_done),
        .bit_done_i   (bit_done),
        .load_o       (load),
        .shift_o      (shift),
        .clr_timer_o  (clr_timer),
        .clr_bit_o    (clr_bit),
        .inc_bit_o    (inc_bit),
        .sel_par_o    (sel_par),
        .busy_o       (busy),
        .sent_o       (sent)
    );

    assign sout = sel_par ? par_bit : frame_bit;

    // R3
    line_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !timer_done) |=> $stable(sout));

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(load)) |-> sout);
endmodule

// File: tb/serial_tx_hs_tb_top.sv
module serial_tx_hs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_000_000;
    localparam int BAUD       = 100_000;
    localparam int DIV        = CLK_HZ / BAUD;
    localparam int NVEC       = 6;
    // each entry: {data byte, expected odd-parity bit}
    localparam logic [8:0] VEC [NVEC] = '{
        9'h001, 9'h1FF, 9'h14B, 9'h002, 9'h100, 9'h00E
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       send_req;
    logic [7:0] din;
    logic       sent;
    logic       sout;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_tx_hs #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(8)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .send_req (send_req),
        .din      (din),
        .sent     (sent),
        .sout     (sout)
    );

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic run_frame(logic [7:0] d, logic p, int hold, logic [7:0] d_late);
        @(negedge clk);
        din      = d;
        send_req = 1'b1;
        @(posedge clk);
        #1;
        chk("R3 start bit at edge k", sout, 1'b0);
        chk("R6 sent low at frame start", sent, 1'b0);
        din = d_late;
        repeat (DIV / 2) @(posedge clk);
        #1 chk("R3 start bit mid", sout, 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (DIV) @(posedge clk);
            #1 chk($sformatf("R4/R9 data bit %0d of %h", i, d), sout, d[i]);
        end
        repeat (DIV) @(posedge clk);
        #1 chk($sformatf("R5 parity of %h", d), sout, p);
        repeat (DIV) @(posedge clk);
        #1;
        chk("R6 stop bit", sout, 1'b1);
        chk("R6 sent low in stop", sent, 1'b0);
        repeat (DIV - DIV / 2 - 1) @(posedge clk);
        #1 chk("R6 sent low one cycle early", sent, 1'b0);
        @(posedge clk);
        #1 chk("R6 sent at k+11*DIV", sent, 1'b1);
        repeat (hold) @(posedge clk);
        #1;
        chk("R7 sent held", sent, 1'b1);
        chk("R7 no second frame", sout, 1'b1);
        @(negedge clk) send_req = 1'b0;
        @(posedge clk);
        #1;
        chk("R8 sent falls", sent, 1'b0);
        chk("R8 line idle", sout, 1'b1);
    endtask

    initial begin
        rst      = 1'b1;
        send_req = 1'b0;
        din      = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset sout", sout, 1'b1);
        chk("R1 reset sent", sent, 1'b0);
        @(negedge clk) rst = 1'b0;
        din = 8'h55;
        repeat (2 * DIV) @(posedge clk);
        #1;
        chk("R2 idle sout", sout, 1'b1);
        chk("R2 idle sent", sent, 1'b0);

        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] d;
            d = VEC[v][8:1];
            run_frame(d, VEC[v][0], (v == 0) ? 3 * DIV : 1,
                      (v % 2 == 1) ? ~d : d);
        end

        // reset in the middle of a frame (data 00: bit 2 is low)
        @(negedge clk);
        din      = 8'h00;
        send_req = 1'b1;
        repeat (3 * DIV + DIV / 2) @(posedge clk);
        #1 chk("R4 data bit before reset", sout, 1'b0);
        @(negedge clk) rst = 1'b1;
        #1;
        chk("R1 async reset sout", sout, 1'b1);
        chk("R1 async reset sent", sent, 1'b0);
        @(negedge clk);
        send_req = 1'b0;
        rst      = 1'b0;
        repeat (DIV) @(posedge clk);
        #1 chk("R2 idle after reset", sout, 1'b1);

        // back to back requests right after the handshake closes
        run_frame(8'hC3, 1'b1, 0, 8'h3C);
        run_frame(8'h5B, 1'b0, 0, 8'h5B);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule